// File: doc/BRIEF.md
# Banked pin controller with key-guarded locks

The block is a memory-mapped general-purpose pin controller on a simple 32-bit single-cycle register bus. Pins come in groups of 32. Each group has registers for output state, input state, interrupt status and interrupt mask. Each pin also has its own control word. The control word sets the pin's direction, the edge that raises its interrupt, and a 4-bit debounce code. The debounce code is stored only. No filtering is done.

A per-pin lock bit protects a pin's output and configuration. The lock bits can be rewritten only straight after a magic key is written to an unlock register. Pin inputs pass through a two-stage synchroniser. Selected edges then set sticky status bits, and any unmasked status bit raises the single interrupt line. The number of 32-pin groups is a parameter, default 2 (64 pins), at most 8.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset:
  - every lock bit is 1;
  - every output bit is 0;
  - every control word reads 0x1 (input, no trigger, debounce 0);
  - interrupt status and mask are 0;
  - `irq`, `pin_oe` and `rsp_rdata` are 0.
- R2: Pin n is bit (n & 31) of group n>>5. Group registers are 4 bytes apart from these bases:
  - output state 0x000, input state 0x020;
  - output set 0x040, output clear 0x060;
  - interrupt status 0x080, mask 0x0A0, mask-clear 0x0C0;
  - lock 0x500.

  Control words sit at 0x100 + 4·n. Writes to the output-state and input-state registers are ignored. Unaligned or unmapped accesses read 0 and change nothing.
- R3: A 1 in the output set register drives that pin's output high, and a 1 in the output clear register drives it low. A 0 bit has no effect. The output state register reads back the output bits.
- R4: Bit 0 of a control word is the direction: 1 = input, 0 = output. `pin_oe[n]` is the inverse of bit 0.
- R5: Control bits 4:3 select the interrupt trigger: 0 none, 1 rising, 2 falling, 3 both edges.
- R6: Control bits 8:5 store a debounce code that is read back unchanged. All other control bits read 0.
- R7: Writing 0x00A5A501 to 0x520 enables exactly one following write to a lock register. Any other write, including a wrong key, cancels the enable. Reads do not cancel it. A lock write without the enable is ignored.
- R8: While a pin's lock bit is 1, writes to its control word and to its output set/clear bits are ignored.
- R9: Inputs are synchronised by two flops. A selected edge on `pin_in` sets the status bit on the third rising clock edge at which the new level is present.
- R10: Interrupt status bits are sticky and clear when 1 is written to them. A new edge that arrives in the same cycle as the clear wins.
- R11: Writing 1 to a mask bit masks that pin, and writing 1 to a mask-clear bit unmasks it. Both addresses read the mask. `irq` is high exactly when some status bit is set and unmasked.
- R12: The input state register reads the synchronised level. A change on `pin_in` is first seen by a read accepted on the third edge after the change.
- R13: Read data appears on `rsp_rdata` after the edge that accepts the read. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| pin_in | input | 32·NUM_BANKS | Raw pin levels |
| pin_out | output | 32·NUM_BANKS | Output levels |
| pin_oe | output | 32·NUM_BANKS | Output enables |
| irq | output | 1 | Interrupt request |

## Verification
Wrong internal state shows at the ports within one or two cycles:
- A wrong output or direction bit is visible on `pin_out`/`pin_oe` the cycle after the write.
- A wrongly kept or dropped key enable appears at the next lock readback.
- An edge-pipeline depth that is off by one moves the rise of `irq` a cycle early or late against the third-edge rule.

A behavioural model in the bench predicts all four outputs on every clock. Directed sequences also probe:
- lock misuse;
- the set-versus-clear race on the status bits;
- the synchroniser latency seen through input-state reads.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int ADDR_W = 12;
    localparam int BANK_BITS = 32;
    localparam logic [31:0] UNLOCK_KEY = 32'h00A5_A501;
    localparam logic [ADDR_W-1:0] CTRL_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] LOCK_BASE = 12'h500;
    localparam logic [ADDR_W-1:0] UNLOCK_ADDR = 12'h520;

    // Group selector is address bits 7:5 below 0x100
    typedef enum logic [2:0] {
        GRP_OUT_STATE = 3'd0,
        GRP_IN_STATE  = 3'd1,
        GRP_OUT_SET   = 3'd2,
        GRP_OUT_CLR   = 3'd3,
        GRP_INT_STAT  = 3'd4,
        GRP_INT_MASK  = 3'd5,
        GRP_MASK_CLR  = 3'd6,
        GRP_SPARE     = 3'd7
    } grp_e;

    // Trigger encoding: bit0 = rising, bit1 = falling
    localparam logic [1:0] TRIG_NONE = 2'd0;

    typedef struct packed {
        logic [3:0] deb;
        logic [1:0] trig;
        logic       dir;
    } pin_cfg_t;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2;
    assign prev = st_q.s3;
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge #(
    parameter int N = 64
) (
    input  logic [N-1:0]   lvl,
    input  logic [N-1:0]   prev,
    input  logic [2*N-1:0] trig,
    output logic [N-1:0]   hit
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        logic rise, fall;
        assign rise   = lvl[p] & ~prev[p];
        assign fall   = ~lvl[p] & prev[p];
        assign hit[p] = (trig[2*p] & rise) | (trig[2*p+1] & fall);
    end
endmodule

// File: rtl/pinbank_keyguard.sv
module pinbank_keyguard (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic at_unlock,
    input  logic key_ok,
    output logic armed
);
    typedef struct packed {
        logic armed;
    } key_t;

    key_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.armed = at_unlock & key_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [31:0]                    req_wdata,
    output logic [31:0]                    rsp_rdata,
    input  logic [NUM_BANKS*BANK_BITS-1:0] pin_in,
    output logic [NUM_BANKS*BANK_BITS-1:0] pin_out,
    output logic [NUM_BANKS*BANK_BITS-1:0] pin_oe,
    output logic                           irq
);
    localparam int NPINS = NUM_BANKS * BANK_BITS;
    localparam int PIN_W = $clog2(NPINS);
    localparam int CTRL_END = 32'h100 + NPINS * 4;

    typedef struct packed {
        logic [NPINS-1:0]           out;
        logic [NPINS-1:0]           lock;
        logic [NPINS-1:0]           stat;
        logic [NPINS-1:0]           mask;
        pin_cfg_t [NPINS-1:0]       cfg;
        logic [31:0]                rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0]   in_lvl, in_prev, edge_hit;
    logic [2*NPINS-1:0] trig_vec;
    logic               armed;
    logic               wr, rd, aligned;
    logic               bank_hit, lock_hit, ctrl_hit, unlock_hit;
    grp_e               grp;
    logic [2:0]         bsel;
    logic [PIN_W-1:0]   ctrl_pin;
    logic [31:0]        rd_word;

    // Address decode
    assign wr         = req_valid & req_write;
    assign rd         = req_valid & ~req_write;
    assign aligned    = (req_addr[1:0] == 2'b00);
    assign grp        = grp_e'(req_addr[7:5]);
    assign bsel       = req_addr[4:2];
    assign bank_hit   = aligned && (req_addr[11:8] == 4'h0);
    assign lock_hit   = aligned && (req_addr[11:5] == LOCK_BASE[11:5]);
    assign unlock_hit = aligned && (req_addr == UNLOCK_ADDR);
    assign ctrl_hit   = aligned && (req_addr >= CTRL_BASE) &&
                        ({20'd0, req_addr} < 32'(CTRL_END));
    assign ctrl_pin   = PIN_W'((req_addr - CTRL_BASE) >> 2);

    pinbank_sync #(.N(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .lvl  (in_lvl),
        .prev (in_prev)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_trig
        assign trig_vec[2*p +: 2] = st_q.cfg[p].trig;
        assign pin_oe[p]          = ~st_q.cfg[p].dir;
    end

    pinbank_edge #(.N(NPINS)) u_edge (
        .lvl (in_lvl),
        .prev(in_prev),
        .trig(trig_vec),
        .hit (edge_hit)
    );

    pinbank_keyguard u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr),
        .at_unlock(unlock_hit),
        .key_ok   (req_wdata == UNLOCK_KEY),
        .armed    (armed)
    );

    always_comb begin
        st_d    = st_q;
        rd_word = '0;

        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit && bsel == 3'(b)) begin
                unique case (grp)
                    GRP_OUT_STATE: rd_word = st_q.out[b*32 +: 32];
                    GRP_IN_STATE:  rd_word = in_lvl[b*32 +: 32];
                    GRP_INT_STAT:  rd_word = st_q.stat[b*32 +: 32];
                    GRP_INT_MASK,
                    GRP_MASK_CLR:  rd_word = st_q.mask[b*32 +: 32];
                    default:       rd_word = '0;
                endcase
                if (wr) begin
                    unique case (grp)
                        GRP_OUT_SET:
                            st_d.out[b*32 +: 32] = st_q.out[b*32 +: 32] |
                                (req_wdata & ~st_q.lock[b*32 +: 32]);
                        GRP_OUT_CLR:
                            st_d.out[b*32 +: 32] = st_q.out[b*32 +: 32] &
                                ~(req_wdata & ~st_q.lock[b*32 +: 32]);
                        GRP_INT_STAT:
                            st_d.stat[b*32 +: 32] = st_q.stat[b*32 +: 32] & ~req_wdata;
                        GRP_INT_MASK:
                            st_d.mask[b*32 +: 32] = st_q.mask[b*32 +: 32] | req_wdata;
                        GRP_MASK_CLR:
                            st_d.mask[b*32 +: 32] = st_q.mask[b*32 +: 32] & ~req_wdata;
                        default: ;
                    endcase
                end
            end
            if (lock_hit && bsel == 3'(b)) begin
                rd_word = st_q.lock[b*32 +: 32];
                if (wr && armed) st_d.lock[b*32 +: 32] = req_wdata;
            end
        end

        for (int p = 0; p < NPINS; p++) begin
            if (ctrl_hit && ctrl_pin == PIN_W'(p)) begin
                rd_word = {23'd0, st_q.cfg[p].deb, st_q.cfg[p].trig, 2'b00, st_q.cfg[p].dir};
                if (wr && !st_q.lock[p]) begin
                    st_d.cfg[p].deb  = req_wdata[8:5];
                    st_d.cfg[p].trig = req_wdata[4:3];
                    st_d.cfg[p].dir  = req_wdata[0];
                end
            end
        end

        // Edge capture after the clear so a same-cycle edge survives
        st_d.stat = st_d.stat | edge_hit;

        if (rd) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lock <= '1;
            for (int p = 0; p < NPINS; p++) begin
                st_q.cfg[p] <= '{deb: 4'd0, trig: TRIG_NONE, dir: 1'b1};
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out   = st_q.out;
    assign rsp_rdata = st_q.rdata;
    assign irq       = |(st_q.stat & ~st_q.mask);
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int NPINS = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [11:0]      req_addr,
    input logic [31:0]      req_wdata,
    input logic [31:0]      rsp_rdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] lock_q,
    input logic [NPINS-1:0] stat_q,
    input logic             armed,
    input logic [NPINS-1:0] edge_hit
);
    // R7
    lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != $past(lock_q)) |-> $past(armed));

    // R7
    key_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && req_valid && req_write &&
         !(req_addr == 12'h520 && req_wdata == 32'h00A5_A501)) |=> !armed);

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ $past(pin_out)) & $past(lock_q)) == '0);

    // R10
    stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~$past(stat_q) & ~$past(edge_hit)) == '0);

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q != '0));

    // R4
    oe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(req_valid && req_write));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> $past(req_valid && !req_write));
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .lock_q   (st_q.lock),
    .stat_q   (st_q.stat),
    .armed    (armed),
    .edge_hit (edge_hit)
);

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb;
    localparam int NP = 64;
    localparam logic [31:0] KEY = 32'h00A5_A501;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic [NP-1:0] pin_in = 64'h40;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pinbank_ctrl #(.NUM_BANKS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [NP-1:0] m_out, m_lock, m_stat, m_mask, m_s1, m_s2, m_s3, mv_hit;
    bit            m_dir [NP];
    int            m_trig [NP];
    int            m_deb [NP];
    bit            m_armed;
    logic [31:0]   m_rd, mv_rd;
    int            ma, mb, mg, mp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out = '0; m_lock = '1; m_stat = '0; m_mask = '0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_armed = 0; m_rd = '0;
            for (int p = 0; p < NP; p++) begin
                m_dir[p] = 1; m_trig[p] = 0; m_deb[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                mv_hit[p] = ((m_trig[p] == 1 || m_trig[p] == 3) && m_s2[p] && !m_s3[p]) ||
                            ((m_trig[p] >= 2) && !m_s2[p] && m_s3[p]);
            end
            mv_rd = '0;
            ma = int'(req_addr);
            if (req_valid && (ma % 4) == 0) begin
                if (ma < 'h100) begin
                    mb = (ma / 4) % 8;
                    mg = ma / 32;
                    if (mb < 2) begin
                        case (mg)
                            0: mv_rd = m_out[mb*32 +: 32];
                            1: mv_rd = m_s2[mb*32 +: 32];
                            4: mv_rd = m_stat[mb*32 +: 32];
                            5, 6: mv_rd = m_mask[mb*32 +: 32];
                            default: mv_rd = '0;
                        endcase
                        if (req_write) begin
                            for (int i = 0; i < 32; i++) begin
                                if (req_wdata[i]) begin
                                    case (mg)
                                        2: if (!m_lock[mb*32+i]) m_out[mb*32+i] = 1'b1;
                                        3: if (!m_lock[mb*32+i]) m_out[mb*32+i] = 1'b0;
                                        4: m_stat[mb*32+i] = 1'b0;
                                        5: m_mask[mb*32+i] = 1'b1;
                                        6: m_mask[mb*32+i] = 1'b0;
                                        default: ;
                                    endcase
                                end
                            end
                        end
                    end
                end else if (ma >= 'h100 && ma < 'h200) begin
                    mp = (ma - 'h100) / 4;
                    mv_rd = 32'((m_deb[mp] << 5) | (m_trig[mp] << 3) | int'(m_dir[mp]));
                    if (req_write && !m_lock[mp]) begin
                        m_dir[mp]  = req_wdata[0];
                        m_trig[mp] = int'(req_wdata[4:3]);
                        m_deb[mp]  = int'(req_wdata[8:5]);
                    end
                end else if (ma >= 'h500 && ma < 'h508) begin
                    mb = (ma - 'h500) / 4;
                    mv_rd = m_lock[mb*32 +: 32];
                    if (req_write && m_armed) m_lock[mb*32 +: 32] = req_wdata;
                end
            end
            if (req_valid && req_write) m_armed = (ma == 'h520) && (req_wdata == KEY);
            m_stat = m_stat | mv_hit;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            if (req_valid && !req_write) m_rd = mv_rd;
        end
    end

    // Cycle comparison against the model, 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            logic [NP-1:0] exp_oe;
            for (int p = 0; p < NP; p++) exp_oe[p] = !m_dir[p];
            chk("R3 pin_out vs model", pin_out, m_out);
            chk("R4 pin_oe vs model", pin_oe, exp_oe);
            chk("R11 irq vs model", 64'(irq), 64'(|(m_stat & ~m_mask)));
            chk("R13 rsp_rdata vs model", 64'(rsp_rdata), 64'(m_rd));
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk);
        #1;
        chk(tag, 64'(rsp_rdata), 64'(exp));
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1;
        idle(1);
        // R1 reset state
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 irq", 64'(irq), 0);
        chk("R1 rdata", 64'(rsp_rdata), 0);
        rd_chk(12'h500, 32'hFFFF_FFFF, "R1 lock bank0");
        rd_chk(12'h504, 32'hFFFF_FFFF, "R1 lock bank1");
        rd_chk(12'h100, 32'h1, "R1 ctrl pin0");
        rd_chk(12'h080, 32'h0, "R1 int status");
        rd_chk(12'h0A0, 32'h0, "R1 mask");

        // R8 locked pins ignore set and control writes
        bus_wr(12'h040, 32'h9);
        rd_chk(12'h000, 32'h0, "R8 set ignored while locked");
        bus_wr(12'h10C, 32'h0);
        rd_chk(12'h10C, 32'h1, "R8 ctrl ignored while locked");

        // R7 wrong key and missing key
        bus_wr(12'h520, 32'h00A5_A500);
        bus_wr(12'h500, 32'h0);
        rd_chk(12'h500, 32'hFFFF_FFFF, "R7 wrong key");
        bus_wr(12'h500, 32'h0);
        rd_chk(12'h500, 32'hFFFF_FFFF, "R7 no key");

        // R7 key survives a read, enables one write only
        bus_wr(12'h520, KEY);
        rd_chk(12'h000, 32'h0, "R7 read between key and lock write");
        bus_wr(12'h500, 32'h0);
        rd_chk(12'h500, 32'h0, "R7 keyed lock write");
        bus_wr(12'h500, 32'hFFFF_0000);
        rd_chk(12'h500, 32'h0, "R7 second lock write ignored");

        // R7 other write cancels
        bus_wr(12'h520, KEY);
        bus_wr(12'h0C0, 32'h0);
        bus_wr(12'h504, 32'h0);
        rd_chk(12'h504, 32'hFFFF_FFFF, "R7 cancel by other write");
        bus_wr(12'h520, KEY);
        bus_wr(12'h504, 32'h0);
        rd_chk(12'h504, 32'h0, "R7 bank1 unlock");

        // R6 / R4 control word
        bus_wr(12'h10C, 32'h152);
        rd_chk(12'h10C, 32'h150, "R6 debounce readback");
        chk("R4 pin3 output enable", pin_oe, 64'h8);

        // R3 set and clear
        bus_wr(12'h040, 32'h9);
        chk("R3 set", pin_out, 64'h9);
        rd_chk(12'h000, 32'h9, "R3 out state");
        bus_wr(12'h060, 32'h1);
        chk("R3 clear", pin_out, 64'h8);
        bus_wr(12'h060, 32'h0);
        bus_wr(12'h040, 32'h0);
        chk("R3 zero bits no effect", pin_out, 64'h8);

        // R2 map and read-only registers
        bus_wr(12'h000, 32'hFFFF_FFFF);
        rd_chk(12'h000, 32'h8, "R2 out state read-only");
        bus_wr(12'h1A0, 32'h0);
        bus_wr(12'h044, 32'h100);
        chk("R2 pin40 is bank1 bit8", pin_out, 64'h0000_0100_0000_0008);
        chk("R2 pin40 oe", pin_oe, 64'h0000_0100_0000_0008);
        rd_chk(12'h004, 32'h100, "R2 bank1 out state");
        rd_chk(12'h020, 32'h40, "R2 bank0 input state");
        rd_chk(12'h024, 32'h0, "R2 bank1 input state");
        rd_chk(12'h102, 32'h0, "R2 unaligned read");

        // R8 single pin lock
        bus_wr(12'h520, KEY);
        bus_wr(12'h500, 32'h8);
        bus_wr(12'h060, 32'h8);
        chk("R8 clear ignored on locked pin", pin_out, 64'h0000_0100_0000_0008);
        bus_wr(12'h10C, 32'h1);
        rd_chk(12'h10C, 32'h150, "R8 ctrl held on locked pin");
        bus_wr(12'h520, KEY);
        bus_wr(12'h500, 32'h0);

        // R5 trigger configuration
        bus_wr(12'h114, 32'h9);
        bus_wr(12'h118, 32'h11);
        bus_wr(12'h11C, 32'h19);
        bus_wr(12'h120, 32'h1);
        idle(4);

        // R9 third-edge latency
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(posedge clk); #1; chk("R9 edge 1", 64'(irq), 0);
        @(posedge clk); #1; chk("R9 edge 2", 64'(irq), 0);
        @(posedge clk); #1; chk("R9 edge 3", 64'(irq), 1);
        rd_chk(12'h080, 32'h20, "R9 status bit");

        // R10 clear by writing one
        bus_wr(12'h080, 32'h20);
        rd_chk(12'h080, 32'h0, "R10 w1c");
        chk("R10 irq low", 64'(irq), 0);

        // R5 patterns
        pin_in[8] = 1'b1; idle(5);
        rd_chk(12'h080, 32'h0, "R5 none trigger");
        pin_in[6] = 1'b0; idle(5);
        rd_chk(12'h080, 32'h40, "R5 falling");
        bus_wr(12'h080, 32'h40);
        pin_in[6] = 1'b1; idle(5);
        rd_chk(12'h080, 32'h0, "R5 falling ignores rise");
        pin_in[5] = 1'b0; idle(5);
        rd_chk(12'h080, 32'h0, "R5 rising ignores fall");
        pin_in[7] = 1'b1; idle(5);
        rd_chk(12'h080, 32'h80, "R5 both on rise");
        bus_wr(12'h080, 32'h80);
        pin_in[7] = 1'b0; idle(5);
        rd_chk(12'h080, 32'h80, "R5 both on fall");

        // R11 mask and mask clear
        chk("R11 irq unmasked", 64'(irq), 1);
        bus_wr(12'h0A0, 32'h80);
        chk("R11 irq masked", 64'(irq), 0);
        rd_chk(12'h0A0, 32'h80, "R11 mask read");
        rd_chk(12'h0C0, 32'h80, "R11 mask via clear addr");
        rd_chk(12'h080, 32'h80, "R11 status kept under mask");
        bus_wr(12'h0C0, 32'h80);
        chk("R11 irq unmasked again", 64'(irq), 1);
        bus_wr(12'h080, 32'h80);
        chk("R11 irq after clear", 64'(irq), 0);

        // R12 input state latency
        @(negedge clk);
        pin_in[9] = 1'b1;
        req_valid = 1; req_write = 0; req_addr = 12'h020;
        @(posedge clk); #1; chk("R12 read at edge 1", 64'(rsp_rdata[9]), 0);
        @(posedge clk); #1; chk("R12 read at edge 2", 64'(rsp_rdata[9]), 0);
        @(posedge clk); #1; chk("R12 read at edge 3", 64'(rsp_rdata[9]), 1);
        @(negedge clk);
        req_valid = 0;
        idle(2);

        // R10 edge beats simultaneous clear
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h080; req_wdata = 32'h20;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        rd_chk(12'h080, 32'h20, "R10 set wins over clear");

        // R13 read data holds across writes
        bus_wr(12'h0A0, 32'h0);
        idle(2);
        chk("R13 rdata held", 64'(rsp_rdata), 64'h20);

        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule